// File: doc/BRIEF.md
# Prioritized Restart Interrupt Controller

This block sits beside a small processor core and decides which of five interrupt sources the core takes next. The sources are a nonmaskable trap, three restart inputs at fixed ranks (called 7.5, 6.5 and 5.5 after their vector slots), and a general request line. The trap and the 7.5 input are caught on rising edges and held in capture flops. The 6.5, 5.5 and general inputs are read as levels at the moment of decision.

Software controls three mask bits and a global enable. The core raises a one-cycle sample strobe at the next-to-last clock of each instruction. On that edge the block picks the highest-ranked pending source. On the following cycle it issues a one-cycle accept pulse with the source code and, for restart sources, a fixed jump address. When the general request wins, the block flags that an acknowledge cycle is needed in place of an ordinary read and that the program counter must not advance. Any accepted interrupt turns the global enable off.

Top module: `rst_irq_arbiter`

## Requirements
- R1: After reset, `accept`, `ack_cycle` and `ien_state` are 0 and all three mask bits are set, so a held 6.5 input with the enable on is not accepted until it is unmasked.
- R2: When several sources are pending at a sample, the winner is, from highest rank down: trap, 7.5, 6.5, 5.5, general request.
- R3: The trap is accepted even when the global enable is off and every mask bit is set.
- R4: The trap is pending only if a rising edge of `trap_pin` has been caught and the pin is still high at the sample. Its capture flop is cleared on acceptance, so a pin held high is taken once.
- R5: A rising edge on `rst75_pin` is held until accepted, even if the pin falls again. Acceptance clears the capture flop, and a mask write with `mask_wdata[3]`=1 also clears it.
- R6: The 6.5 and 5.5 inputs are levels: a pin that is low at the sample is not taken, and a pin held high is taken again at each sample while enabled.
- R7: `mask_wdata[0]`, `[1]` and `[2]` mask 5.5, 6.5 and 7.5 (1 = masked) when `mask_wr` is 1. Masking 7.5 does not stop its edge capture, so unmasking later lets a held edge through.
- R8: Sources are examined only on a clock edge where `sample` is 1. A pending source with `sample` low produces no accept and leaves the enable unchanged.
- R9: `ien_set` turns the global enable on and `ien_clr` turns it off. Acceptance of any source turns it off and wins over `ien_set` in the same cycle. With the enable off, only the trap can be taken.
- R10: `src_code` is 1 trap, 2 for 7.5, 3 for 6.5, 4 for 5.5, and 5 general. `vector` is 0x0024 trap, 0x003C for 7.5, 0x0034 for 6.5, 0x002C for 5.5, and 0 for the general request.
- R11: `ack_cycle` is 1 exactly when the accepted source is the general request. It marks an acknowledge cycle and a held program counter.
- R12: `accept`, `src_code`, `vector` and `ack_cycle` are registered. They appear in the cycle after the sample edge and stay valid for one cycle. With no accept, `src_code` and `vector` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_pin | input | 1 | Nonmaskable trap input, edge and level |
| rst75_pin | input | 1 | Restart 7.5 input, rising edge |
| rst65_pin | input | 1 | Restart 6.5 input, level |
| rst55_pin | input | 1 | Restart 5.5 input, level |
| gen_req_pin | input | 1 | General request input, level |
| mask_wr | input | 1 | Mask write strobe |
| mask_wdata | input | 4 | Mask bits [2:0], bit 3 clears 7.5 capture |
| ien_set | input | 1 | Global enable on strobe |
| ien_clr | input | 1 | Global enable off strobe |
| sample | input | 1 | Instruction sampling point strobe from core |
| accept | output | 1 | One-cycle accept pulse |
| src_code | output | 3 | Accepted source code |
| vector | output | 16 | Fixed jump address of accepted restart |
| ack_cycle | output | 1 | Acknowledge cycle needed, program counter held |
| ien_state | output | 1 | Current global enable |

## Verification
The hardest situations to reach are those where a caught edge and the live pin level disagree. One is a trap edge whose pin has fallen again by the sample. Another is a 7.5 edge that is still held after its pin has dropped, either while masked or until a mask write clears it. The stimulus pulses these pins between samples and then writes masks or moves the enable before sampling. The level sources, mask bits and enable are swept over every combination with the edge sources idle, and the expected winner is computed from the rank order.

// File: rtl/rst_irq_pkg.sv
package rst_irq_pkg;

    parameter int VEC_W  = 16;
    parameter int N_SRC  = 5;
    parameter int MASK_W = 3;

    typedef enum logic [2:0] {
        SRC_NONE = 3'd0,
        SRC_TRAP = 3'd1,
        SRC_R75  = 3'd2,
        SRC_R65  = 3'd3,
        SRC_R55  = 3'd4,
        SRC_GEN  = 3'd5
    } src_e;

    typedef struct packed {
        logic             accept;
        src_e             src;
        logic [VEC_W-1:0] vector;
        logic             ack;
    } grant_t;

    // restart slot n.5 jumps to n.5 * 8
    function automatic logic [VEC_W-1:0] vec_of(input src_e s);
        case (s)
            SRC_TRAP: vec_of = VEC_W'(16'h0024);
            SRC_R75:  vec_of = VEC_W'(16'h003C);
            SRC_R65:  vec_of = VEC_W'(16'h0034);
            SRC_R55:  vec_of = VEC_W'(16'h002C);
            default:  vec_of = '0;
        endcase
    endfunction

endpackage

// File: rtl/irq_edge_catch.sv
module irq_edge_catch (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic clr,
    output logic caught
);
    logic prev_q;
    logic rise;

    assign rise = pin & ~prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= pin;
            caught <= 1'b0;
        end else begin
            prev_q <= pin;
            if (rise)
                caught <= 1'b1;
            else if (clr)
                caught <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
    import rst_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mask_wr,
    input  logic [MASK_W-1:0] mask_bits,
    input  logic              ien_set,
    input  logic              ien_clr,
    input  logic              taken,
    output logic [MASK_W-1:0] mask_q,
    output logic              ien_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '1;
            ien_q  <= 1'b0;
        end else begin
            if (mask_wr)
                mask_q <= mask_bits;
            if (taken)
                ien_q <= 1'b0;
            else if (ien_set)
                ien_q <= 1'b1;
            else if (ien_clr)
                ien_q <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
    import rst_irq_pkg::*;
(
    input  logic [N_SRC-1:0] req,
    output logic [N_SRC-1:0] onehot,
    output src_e             winner
);
    // index 0 is the highest rank
    always_comb begin
        onehot = '0;
        winner = SRC_NONE;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (req[i]) begin
                onehot = '0;
                onehot[i] = 1'b1;
                winner = src_e'(i + 1);
            end
        end
    end
endmodule

// File: rtl/rst_irq_arbiter.sv
module rst_irq_arbiter
    import rst_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              trap_pin,
    input  logic              rst75_pin,
    input  logic              rst65_pin,
    input  logic              rst55_pin,
    input  logic              gen_req_pin,
    input  logic              mask_wr,
    input  logic [MASK_W:0]   mask_wdata,
    input  logic              ien_set,
    input  logic              ien_clr,
    input  logic              sample,
    output logic              accept,
    output logic [2:0]        src_code,
    output logic [VEC_W-1:0]  vector,
    output logic              ack_cycle,
    output logic              ien_state
);
    localparam int CLR75_BIT = MASK_W;

    logic              trap_caught, r75_caught;
    logic [MASK_W-1:0] mask_q;
    logic              ien_q;
    logic [N_SRC-1:0]  req, onehot;
    src_e              winner;
    logic              take;
    grant_t            grant_q;

    assign take = sample & (winner != SRC_NONE);

    irq_edge_catch u_trap_catch (
        .clk(clk), .rst(rst), .pin(trap_pin),
        .clr(take && winner == SRC_TRAP), .caught(trap_caught)
    );

    irq_edge_catch u_r75_catch (
        .clk(clk), .rst(rst), .pin(rst75_pin),
        .clr((take && winner == SRC_R75) || (mask_wr && mask_wdata[CLR75_BIT])),
        .caught(r75_caught)
    );

    irq_ctrl_regs u_regs (
        .clk(clk), .rst(rst), .mask_wr(mask_wr),
        .mask_bits(mask_wdata[MASK_W-1:0]),
        .ien_set(ien_set), .ien_clr(ien_clr), .taken(take),
        .mask_q(mask_q), .ien_q(ien_q)
    );

    assign req[0] = trap_caught & trap_pin;
    assign req[1] = ien_q & r75_caught  & ~mask_q[2];
    assign req[2] = ien_q & rst65_pin   & ~mask_q[1];
    assign req[3] = ien_q & rst55_pin   & ~mask_q[0];
    assign req[4] = ien_q & gen_req_pin;

    irq_pick u_pick (.req(req), .onehot(onehot), .winner(winner));

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_q <= '0;
        end else if (take) begin
            grant_q.accept <= 1'b1;
            grant_q.src    <= winner;
            grant_q.vector <= vec_of(winner);
            grant_q.ack    <= (winner == SRC_GEN);
        end else begin
            grant_q <= '0;
        end
    end

    assign accept    = grant_q.accept;
    assign src_code  = grant_q.src;
    assign vector    = grant_q.vector;
    assign ack_cycle = grant_q.ack;
    assign ien_state = ien_q;

    AST_ACCEPT_AT_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        accept |-> $past(sample)); // R8
    AST_ENABLE_DROPS: assert property (@(posedge clk) disable iff (rst)
        accept |-> !ien_state); // R9
    AST_TRAP_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (accept && src_code == SRC_TRAP) |-> $past(trap_pin)); // R4
    AST_MASK_HONOURED: assert property (@(posedge clk) disable iff (rst)
        (accept && src_code == SRC_R65) |-> !$past(mask_q[1])); // R7
    AST_ACK_ONLY_GEN: assert property (@(posedge clk) disable iff (rst)
        ack_cycle |-> (accept && src_code == SRC_GEN)); // R11
    AST_SINGLE_WINNER: assert property (@(posedge clk) disable iff (rst)
        $onehot0(onehot)); // R2
    AST_GATED_BY_ENABLE: assert property (@(posedge clk) disable iff (rst)
        (accept && src_code != SRC_TRAP) |-> $past(ien_state)); // R9
endmodule

// File: tb/rst_irq_arbiter_tb_top.sv
module rst_irq_arbiter_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic trap_pin = 0, rst75_pin = 0, rst65_pin = 0, rst55_pin = 0, gen_req_pin = 0;
    logic mask_wr = 0;
    logic [3:0] mask_wdata = 0;
    logic ien_set = 0, ien_clr = 0, sample = 0;
    logic accept, ack_cycle, ien_state;
    logic [2:0] src_code;
    logic [15:0] vector;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    rst_irq_arbiter dut_i (
        .clk(clk), .rst(rst), .trap_pin(trap_pin), .rst75_pin(rst75_pin),
        .rst65_pin(rst65_pin), .rst55_pin(rst55_pin), .gen_req_pin(gen_req_pin),
        .mask_wr(mask_wr), .mask_wdata(mask_wdata), .ien_set(ien_set),
        .ien_clr(ien_clr), .sample(sample), .accept(accept), .src_code(src_code),
        .vector(vector), .ack_cycle(ack_cycle), .ien_state(ien_state)
    );

    function automatic logic [15:0] exp_vec(input logic [2:0] s);
        case (s)
            3'd1: return 16'h0024;
            3'd2: return 16'h003C;
            3'd3: return 16'h0034;
            3'd4: return 16'h002C;
            default: return 16'h0000;
        endcase
    endfunction

    // packed {accept, src, vector, ack}
    function automatic logic [20:0] pack_exp(input logic [2:0] s);
        return {s != 3'd0, s, exp_vec(s), s == 3'd5};
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic check_grant(input string req, input logic [2:0] s);
        check(req, 32'({accept, src_code, vector, ack_cycle}), 32'(pack_exp(s)));
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_sample();
        @(negedge clk) sample = 1'b1;
        @(negedge clk) sample = 1'b0;
    endtask

    task automatic write_mask(input logic [3:0] d);
        @(negedge clk) begin mask_wr = 1'b1; mask_wdata = d; end
        @(negedge clk) mask_wr = 1'b0;
    endtask

    task automatic enable(input logic on);
        @(negedge clk) begin ien_set = on; ien_clr = ~on; end
        @(negedge clk) begin ien_set = 1'b0; ien_clr = 1'b0; end
    endtask

    task automatic pulse75();
        @(negedge clk) rst75_pin = 1'b1;
        @(negedge clk) rst75_pin = 1'b0;
    endtask

    task automatic report();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        report();
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        check("R1 accept", 32'(accept), 0);
        check("R1 ien", 32'(ien_state), 0);
        rst65_pin = 1'b1;
        enable(1'b1);
        do_sample();
        check_grant("R1 masked after reset", 3'd0);
        check("R1 ien kept", 32'(ien_state), 1);
        rst65_pin = 1'b0;

        // R6 R7 R9 R10 R11: sweep of level pins, masks and enable
        for (int p = 0; p < 8; p++) begin
            for (int m = 0; m < 8; m++) begin
                for (int e = 0; e < 2; e++) begin
                    logic [2:0] s;
                    rst65_pin = p[0]; rst55_pin = p[1]; gen_req_pin = p[2];
                    write_mask({1'b0, 3'(m)});
                    enable(e[0]);
                    s = 3'd0;
                    if (e[0]) begin
                        if (p[0] && !m[1]) s = 3'd3;
                        else if (p[1] && !m[0]) s = 3'd4;
                        else if (p[2]) s = 3'd5;
                    end
                    do_sample();
                    check_grant("R6 R7 R10 R11 sweep", s);
                    check("R9 ien after sample", 32'(ien_state), 32'(e[0] && s == 3'd0));
                    tick();
                    check("R12 pulse ends", 32'({accept, src_code, vector}), 0);
                end
            end
        end
        rst65_pin = 0; rst55_pin = 0; gen_req_pin = 0;

        // R3 trap with enable off and all masked
        write_mask(4'b0111);
        enable(1'b0);
        @(negedge clk) trap_pin = 1'b1;
        do_sample();
        check_grant("R3 trap nonmaskable", 3'd1);
        do_sample();
        check_grant("R4 trap held high taken once", 3'd0);
        @(negedge clk) trap_pin = 1'b0;
        @(negedge clk) trap_pin = 1'b1;
        @(negedge clk) trap_pin = 1'b0;
        do_sample();
        check_grant("R4 trap edge but pin low", 3'd0);

        // R5 7.5 edge held after pin falls
        write_mask(4'b0000);
        enable(1'b1);
        pulse75();
        repeat (3) tick();
        do_sample();
        check_grant("R5 r75 held edge", 3'd2);
        enable(1'b1);
        do_sample();
        check_grant("R5 r75 cleared on accept", 3'd0);
        pulse75();
        write_mask(4'b1000);
        do_sample();
        check_grant("R5 r75 cleared by mask write", 3'd0);

        // R7 masked 7.5 keeps its edge
        write_mask(4'b0100);
        pulse75();
        do_sample();
        check_grant("R7 r75 masked", 3'd0);
        write_mask(4'b0000);
        do_sample();
        check_grant("R7 r75 after unmask", 3'd2);

        // R8 no sample, no accept
        enable(1'b1);
        gen_req_pin = 1'b1;
        repeat (5) begin
            tick();
            check("R8 no accept without sample", 32'(accept), 0);
        end
        check("R8 ien unchanged", 32'(ien_state), 1);
        enable(1'b0);
        do_sample();
        check_grant("R9 disabled gen ignored", 3'd0);
        gen_req_pin = 1'b0;

        // R2 priority ladder
        enable(1'b1);
        rst65_pin = 1; rst55_pin = 1; gen_req_pin = 1;
        pulse75();
        @(negedge clk) trap_pin = 1'b0;
        @(negedge clk) trap_pin = 1'b1;
        do_sample();
        check_grant("R2 trap first", 3'd1);
        check("R9 ien kept off by trap", 32'(ien_state), 0);
        enable(1'b1);
        do_sample();
        check_grant("R2 r75 second", 3'd2);
        enable(1'b1);
        do_sample();
        check_grant("R2 r65 third", 3'd3);
        enable(1'b1);
        do_sample();
        check_grant("R6 r65 level taken again", 3'd3);
        rst65_pin = 0;
        enable(1'b1);
        do_sample();
        check_grant("R2 r55 fourth", 3'd4);
        rst55_pin = 0;
        enable(1'b1);
        do_sample();
        check_grant("R2 R11 gen last", 3'd5);
        gen_req_pin = 0; trap_pin = 0;

        // R9 accept beats ien_set in the same cycle
        gen_req_pin = 1;
        enable(1'b1);
        @(negedge clk) begin sample = 1'b1; ien_set = 1'b1; end
        @(negedge clk) begin sample = 1'b0; ien_set = 1'b0; end
        check_grant("R9 accept with set", 3'd5);
        check("R9 accept wins over set", 32'(ien_state), 0);
        gen_req_pin = 0;

        report();
    end
endmodule